// File: doc/BRIEF.md
# SIMD Single-Structure Load/Store Decoder

This block is a purely combinational decoder for one 32-bit instruction word from a family of SIMD single-structure memory instructions. It checks the fixed family bits and pulls out the destination, base and offset register numbers. It also works out the shape of the transfer: how many elements, how wide each element is, how wide the vector register is, and which lane is touched. The flags it produces say whether the access is a load, whether it writes back the base register, and whether one element is replicated across every lane. For post-index words it also gives the immediate increment.

Each lane-size case has its own legality rules, and illegal combinations raise an undefined flag. A word-lane encoding with the low size bit set is read as a doubleword access. When the feature-enable input is low, every word is undefined. When the flag is raised, every other output is forced to zero so that downstream stages can ignore it.

The block has no stream data path, so it has no valid/ready handshake. The instruction word and feature-enable bit are plain control inputs, and the outputs follow them in the same cycle.

Top module: `sld_struct_decoder`

## Requirements
- R1: When `feat_en` is 0, `undef` is 1 for every instruction word.
- R2: Bit 31 must be 0 and bits 29:24 must be 001101, otherwise `undef` is 1.
- R3: Bit 23 = 1 is the post-index class and gives `wback` = 1. Bit 23 = 0 is the no-offset class: it gives `wback` = 0 and requires bits 20:16 to be 00000, otherwise `undef` is 1.
- R4: On a defined word, `rt` = bits 4:0, `rn` = bits 9:5, `rm` = bits 20:16 and `is_load` = bit 22.
- R5: The opcode field is bits 15:13 and R is bit 21. On a defined word, `selem` = {opcode[0], R} + 1, a value from 1 to 4.
- R6: Opcode bits 2:1 = 11 is the replicate form. It is undefined unless bit 22 = 1 and S (bit 12) = 0. When defined it gives `replicate` = 1, `lane_idx` = 0 and `esize` = 8 << size, where size is bits 11:10.
- R7: Opcode bits 2:1 = 00 gives byte lanes: `esize` = 8 and `lane_idx` = {Q, S, size}, where Q is bit 30.
- R8: Opcode bits 2:1 = 01 gives halfword lanes. It is undefined when size[0] = 1. Otherwise `esize` = 16 and `lane_idx` = {Q, S, size[1]}.
- R9: Opcode bits 2:1 = 10 is undefined when size[1] = 1. With size = 00 it gives word lanes: `esize` = 32 and `lane_idx` = {Q, S}.
- R10: Opcode bits 2:1 = 10 with size = 01 is a doubleword lane. It is undefined when S = 1. Otherwise `esize` = 64 and `lane_idx` = Q.
- R11: On a defined word, `datasize` = 64 << Q, that is 64 or 128.
- R12: On a post-index word with Rm = 31, `post_imm` = `selem` × `esize`/8 and `reg_offset` = 0. For the three-element replicate form this gives 3, 6, 12 or 24. With any other Rm, `reg_offset` = 1 and `post_imm` = 0. In the no-offset class, both are 0.
- R13: While `undef` is 1, every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word |
| feat_en | input | 1 | SIMD feature enabled |
| undef | output | 1 | Word is undefined |
| rt | output | 5 | First transfer register |
| rn | output | 5 | Base register |
| rm | output | 5 | Post-index offset register field |
| is_load | output | 1 | Load (1) or store (0) |
| wback | output | 1 | Base register writeback |
| replicate | output | 1 | Load-and-replicate form |
| selem | output | 3 | Element count, 1 to 4 |
| esize | output | 7 | Element size in bits |
| datasize | output | 8 | Register width in bits |
| lane_idx | output | 4 | Lane index |
| post_imm | output | 6 | Post-index immediate in bytes |
| reg_offset | output | 1 | Writeback adds a register |

## Verification
Immediate assertions are evaluated whenever the inputs change, and they cover the cross-output rules:
- a disabled feature always gives an undefined word;
- `wback` matches the class bit;
- a replicate decode always has lane 0;
- halfword lanes stay below 8;
- the element size is a single power of two from 8 to 64;
- a nonzero immediate only appears on a post-index decode, and it equals the element count times the element bytes.

The exact field values depend on combinations of Q, S, size and opcode. Only the bench's scenarios can show them: random words compared against an independent reference model, plus directed words for the undefined corners and for the replicate immediates 3, 6, 12 and 24.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int INSN_W  = 32;
  localparam int REG_W   = 5;
  localparam int LANE_W  = 4;
  localparam int SELEM_W = 3;
  localparam int ESIZE_W = 7;
  localparam int DSIZE_W = 8;
  localparam int IMM_W   = 6;
  localparam int EBYTE_W = 4;
  localparam logic [5:0] FAMILY_TAG = 6'b001101;

  typedef enum logic [1:0] {
    SC_BYTE = 2'd0,
    SC_HALF = 2'd1,
    SC_WORD = 2'd2,
    SC_DBL  = 2'd3
  } scale_e;

  typedef struct packed {
    logic             q;
    logic             post;
    logic             ld;
    logic             rbit;
    logic [REG_W-1:0] rm;
    logic [2:0]       opc;
    logic             s;
    logic [1:0]       size;
    logic [REG_W-1:0] rn;
    logic [REG_W-1:0] rt;
  } fields_t;
endpackage

// File: rtl/sld_field_split.sv
module sld_field_split
  import sld_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output fields_t           f,
  output logic              frame_ok,
  output logic              offset_ok
);
  always_comb begin
    f.q    = insn[30];
    f.post = insn[23];
    f.ld   = insn[22];
    f.rbit = insn[21];
    f.rm   = insn[20:16];
    f.opc  = insn[15:13];
    f.s    = insn[12];
    f.size = insn[11:10];
    f.rn   = insn[9:5];
    f.rt   = insn[4:0];
  end

  assign frame_ok  = (insn[31] == 1'b0) && (insn[29:24] == FAMILY_TAG);
  assign offset_ok = insn[23] || (insn[20:16] == '0);

  always_comb begin
    if (!insn[23] && insn[20:16] != '0)
      p_nooff_rm_r3: assert (!offset_ok) else $error("nonzero Rm accepted in no-offset class");
  end
endmodule

// File: rtl/sld_lane_rules.sv
module sld_lane_rules
  import sld_pkg::*;
(
  input  logic [2:0]        opc,
  input  logic              s,
  input  logic [1:0]        size,
  input  logic              q,
  input  logic              ld,
  output scale_e            eff_scale,
  output logic              repl,
  output logic [LANE_W-1:0] lane,
  output logic              lane_bad
);
  always_comb begin
    eff_scale = SC_BYTE;
    repl      = 1'b0;
    lane      = '0;
    lane_bad  = 1'b0;
    unique case (opc[2:1])
      2'b11: begin
        lane_bad  = !ld || s;
        repl      = 1'b1;
        eff_scale = scale_e'(size);
      end
      2'b00: begin
        eff_scale = SC_BYTE;
        lane      = {q, s, size};
      end
      2'b01: begin
        eff_scale = SC_HALF;
        lane_bad  = size[0];
        lane      = {1'b0, q, s, size[1]};
      end
      default: begin
        lane_bad = size[1];
        if (!size[0]) begin
          eff_scale = SC_WORD;
          lane      = {2'b00, q, s};
        end else begin
          eff_scale = SC_DBL;
          lane_bad  = size[1] || s;
          lane      = {3'b000, q};
        end
      end
    endcase
  end

  always_comb begin
    if (opc[2:1] == 2'b01 && !lane_bad)
      p_half_lane_range_r8: assert (lane < 4'd8) else $error("halfword lane out of range");
    if (opc[2:1] == 2'b10 && size == 2'b01 && !lane_bad)
      p_dbl_promote_r10: assert (eff_scale == SC_DBL && lane < 4'd2) else $error("doubleword promotion wrong");
  end
endmodule

// File: rtl/sld_shape_calc.sv
module sld_shape_calc
  import sld_pkg::*;
(
  input  scale_e             eff_scale,
  input  logic               opc0,
  input  logic               rbit,
  input  logic               q,
  input  logic               post,
  input  logic [REG_W-1:0]   rm,
  output logic [SELEM_W-1:0] selem,
  output logic [ESIZE_W-1:0] esize,
  output logic [DSIZE_W-1:0] dsize,
  output logic [IMM_W-1:0]   imm,
  output logic               reg_off
);
  localparam logic [REG_W-1:0] RM_IMM = '1;

  logic [EBYTE_W-1:0] ebytes;
  logic               use_imm;

  assign selem   = {1'b0, opc0, rbit} + SELEM_W'(1);
  assign ebytes  = EBYTE_W'(1) << eff_scale;
  assign esize   = ESIZE_W'(8) << eff_scale;
  assign dsize   = q ? DSIZE_W'(128) : DSIZE_W'(64);
  assign use_imm = post && (rm == RM_IMM);
  assign reg_off = post && (rm != RM_IMM);
  assign imm     = use_imm ? (IMM_W'(selem) * IMM_W'(ebytes)) : '0;

  always_comb begin
    p_esize_pow2_r9: assert ($onehot(esize) && esize >= 7'd8 && esize <= 7'd64)
      else $error("element size not a power of two in range");
    if (imm != '0)
      p_imm_product_r12: assert (post && ({3'b000, imm} == IMM_W'(selem) * {3'b000, esize[6:3]}))
        else $error("post immediate mismatch");
  end
endmodule

// File: rtl/sld_struct_decoder.sv
module sld_struct_decoder
  import sld_pkg::*;
(
  input  logic [INSN_W-1:0]  insn,
  input  logic               feat_en,
  output logic               undef,
  output logic [REG_W-1:0]   rt,
  output logic [REG_W-1:0]   rn,
  output logic [REG_W-1:0]   rm,
  output logic               is_load,
  output logic               wback,
  output logic               replicate,
  output logic [SELEM_W-1:0] selem,
  output logic [ESIZE_W-1:0] esize,
  output logic [DSIZE_W-1:0] datasize,
  output logic [LANE_W-1:0]  lane_idx,
  output logic [IMM_W-1:0]   post_imm,
  output logic               reg_offset
);
  fields_t            f;
  logic               frame_ok, offset_ok, lane_bad, repl_i, reg_off_i;
  scale_e             eff_scale;
  logic [LANE_W-1:0]  lane_i;
  logic [SELEM_W-1:0] selem_i;
  logic [ESIZE_W-1:0] esize_i;
  logic [DSIZE_W-1:0] dsize_i;
  logic [IMM_W-1:0]   imm_i;

  sld_field_split u_split (
    .insn(insn), .f(f), .frame_ok(frame_ok), .offset_ok(offset_ok)
  );

  sld_lane_rules u_lane (
    .opc(f.opc), .s(f.s), .size(f.size), .q(f.q), .ld(f.ld),
    .eff_scale(eff_scale), .repl(repl_i), .lane(lane_i), .lane_bad(lane_bad)
  );

  sld_shape_calc u_shape (
    .eff_scale(eff_scale), .opc0(f.opc[0]), .rbit(f.rbit), .q(f.q),
    .post(f.post), .rm(f.rm), .selem(selem_i), .esize(esize_i),
    .dsize(dsize_i), .imm(imm_i), .reg_off(reg_off_i)
  );

  logic bad;
  assign bad = !feat_en || !frame_ok || !offset_ok || lane_bad;

  always_comb begin
    undef      = bad;
    rt         = '0;
    rn         = '0;
    rm         = '0;
    is_load    = 1'b0;
    wback      = 1'b0;
    replicate  = 1'b0;
    selem      = '0;
    esize      = '0;
    datasize   = '0;
    lane_idx   = '0;
    post_imm   = '0;
    reg_offset = 1'b0;
    if (!bad) begin
      rt         = f.rt;
      rn         = f.rn;
      rm         = f.rm;
      is_load    = f.ld;
      wback      = f.post;
      replicate  = repl_i;
      selem      = selem_i;
      esize      = esize_i;
      datasize   = dsize_i;
      lane_idx   = lane_i;
      post_imm   = imm_i;
      reg_offset = reg_off_i;
    end
  end

  always_comb begin
    if (!feat_en)
      p_feat_off_r1: assert (undef) else $error("disabled feature decoded");
    if (!undef)
      p_wback_class_r3: assert (wback == insn[23]) else $error("writeback disagrees with class");
    if (!undef && replicate)
      p_repl_lane0_r6: assert (lane_idx == '0 && is_load) else $error("replicate lane not zero");
    if (undef)
      p_undef_quiet_r13: assert (selem == '0 && esize == '0 && datasize == '0 && post_imm == '0)
        else $error("undefined word leaked shape");
  end
endmodule

// File: tb/sld_struct_decoder_tb.sv
module sld_struct_decoder_tb;
  logic        clk = 1'b0;
  logic [31:0] insn;
  logic        feat_en;
  logic        undef, is_load, wback, replicate, reg_offset;
  logic [4:0]  rt, rn, rm;
  logic [2:0]  selem;
  logic [6:0]  esize;
  logic [7:0]  datasize;
  logic [3:0]  lane_idx;
  logic [5:0]  post_imm;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sld_struct_decoder u_dut (
    .insn(insn), .feat_en(feat_en), .undef(undef), .rt(rt), .rn(rn), .rm(rm),
    .is_load(is_load), .wback(wback), .replicate(replicate), .selem(selem),
    .esize(esize), .datasize(datasize), .lane_idx(lane_idx),
    .post_imm(post_imm), .reg_offset(reg_offset)
  );

  typedef struct {
    bit undef; int rt, rn, rm; bit ld, wb, repl, regoff;
    int selem, esize, dsize, lane, imm; string tag;
  } exp_t;

  function automatic exp_t model(input logic [31:0] w, input logic fe);
    exp_t e;
    int sc, opc, sz, q, s, scale;
    bit bad;
    e = '{default: 0, tag: "R13"};
    opc = int'(w[15:13]); sz = int'(w[11:10]); q = int'(w[30]); s = int'(w[12]);
    sc = opc >> 1; scale = 0; bad = 0;
    if (!fe) begin e.undef = 1; e.tag = "R1"; return e; end
    if (w[31] != 1'b0 || w[29:24] != 6'b001101) begin e.undef = 1; e.tag = "R2"; return e; end
    if (!w[23] && w[20:16] != 5'd0) begin e.undef = 1; e.tag = "R3"; return e; end
    case (sc)
      3: begin e.tag = "R6"; bad = !w[22] || s == 1; scale = sz; e.repl = 1; e.lane = 0; end
      0: begin e.tag = "R7"; scale = 0; e.lane = q*8 + s*4 + sz; end
      1: begin e.tag = "R8"; bad = (sz & 1) == 1; scale = 1; e.lane = q*4 + s*2 + (sz >> 1); end
      default: begin
        if (sz >= 2) begin e.tag = "R9"; bad = 1; end
        else if (sz == 0) begin e.tag = "R9"; scale = 2; e.lane = q*2 + s; end
        else begin e.tag = "R10"; bad = s == 1; scale = 3; e.lane = q; end
      end
    endcase
    if (bad) begin e.undef = 1; e.lane = 0; e.repl = 0; return e; end
    e.rt = int'(w[4:0]); e.rn = int'(w[9:5]); e.rm = int'(w[20:16]);
    e.ld = w[22]; e.wb = w[23];
    e.selem = (opc & 1) * 2 + int'(w[21]) + 1;
    e.esize = 8 << scale;
    e.dsize = 64 << q;
    if (w[23] && e.rm == 31) e.imm = e.selem * (e.esize / 8);
    e.regoff = w[23] && e.rm != 31;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s insn=%h actual=%0d expected=%0d", req, insn, act, exp_v);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic fe);
    exp_t e;
    @(negedge clk);
    insn = w; feat_en = fe;
    #1;
    e = model(w, fe);
    chk(undef == e.undef, e.tag, int'(undef), int'(e.undef));
    if (e.undef) begin
      chk({rt, rn, rm, is_load, wback, replicate, selem, esize, datasize, lane_idx, post_imm, reg_offset} == '0,
          "R13", int'(esize), 0);
    end else begin
      chk(int'(rt) == e.rt && int'(rn) == e.rn && int'(rm) == e.rm && is_load == e.ld, "R4", int'(rt), e.rt);
      chk(wback == e.wb, "R3", int'(wback), int'(e.wb));
      chk(int'(selem) == e.selem, "R5", int'(selem), e.selem);
      chk(int'(esize) == e.esize, e.tag, int'(esize), e.esize);
      chk(int'(lane_idx) == e.lane, e.tag, int'(lane_idx), e.lane);
      chk(replicate == e.repl, "R6", int'(replicate), int'(e.repl));
      chk(int'(datasize) == e.dsize, "R11", int'(datasize), e.dsize);
      chk(int'(post_imm) == e.imm && reg_offset == e.regoff, "R12", int'(post_imm), e.imm);
    end
  endtask

  function automatic logic [31:0] mk(input bit q, input bit post, input bit l, input bit r,
                                     input logic [4:0] m, input logic [2:0] op, input bit s,
                                     input logic [1:0] sz);
    return {1'b0, q, 6'b001101, post, l, r, m, op, s, sz, 5'd7, 5'd3};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic fe;
    insn = '0; feat_en = 1'b1;
    void'($urandom(32'd20240611));
    apply(32'h0, 1'b1);                                   // R2 all-zero word
    apply(mk(1, 1, 1, 0, 5'd31, 3'b111, 0, 2'd1), 1'b0);  // R1 disabled
    // R12 three-element replicate immediates 3, 6, 12, 24
    for (int sz = 0; sz < 4; sz++) begin
      apply(mk(1, 1, 1, 0, 5'd31, 3'b111, 0, 2'(sz)), 1'b1);
      chk(int'(post_imm) == (3 << sz), "R12", int'(post_imm), 3 << sz);
    end
    apply(mk(0, 1, 1, 0, 5'd4, 3'b111, 0, 2'd2), 1'b1);   // R12 register offset
    apply(mk(0, 1, 0, 0, 5'd31, 3'b110, 0, 2'd0), 1'b1);  // R6 store replicate undef
    apply(mk(0, 0, 1, 0, 5'd0, 3'b110, 1, 2'd0), 1'b1);   // R6 S=1 undef
    apply(mk(0, 0, 1, 0, 5'd5, 3'b000, 0, 2'd0), 1'b1);   // R3 nonzero Rm
    apply(mk(1, 0, 1, 1, 5'd0, 3'b001, 1, 2'd3), 1'b1);   // R7 lane 15
    apply(mk(1, 0, 0, 0, 5'd0, 3'b010, 1, 2'd1), 1'b1);   // R8 size0 undef
    apply(mk(1, 0, 0, 0, 5'd0, 3'b011, 1, 2'd2), 1'b1);   // R8 lane 7
    apply(mk(1, 0, 1, 0, 5'd0, 3'b100, 1, 2'd2), 1'b1);   // R9 size1 undef
    apply(mk(1, 0, 1, 0, 5'd0, 3'b100, 1, 2'd0), 1'b1);   // R9 lane 3
    apply(mk(1, 1, 1, 1, 5'd31, 3'b101, 0, 2'd1), 1'b1);  // R10 doubleword, imm 32
    apply(mk(1, 0, 1, 0, 5'd0, 3'b100, 1, 2'd1), 1'b1);   // R10 S=1 undef
    for (int i = 0; i < 4000; i++) begin
      w = $urandom;
      if (($urandom % 8) != 0) begin w[31] = 1'b0; w[29:24] = 6'b001101; end
      if (!w[23] && ($urandom % 4) != 0) w[20:16] = 5'd0;
      if (w[23] && ($urandom % 3) == 0) w[20:16] = 5'd31;
      fe = ($urandom % 16) != 0;
      apply(w, fe);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule